// File: doc/BRIEF.md
# Transparent Online Word-Memory March Tester

This controller tests a word-oriented RAM while the system that owns it keeps running. Each stored word carries check bits, either one even-parity bit or a set of Hamming bits chosen at elaboration time. The controller takes idle memory cycles through a request/grant port. It makes four complete passes over the address space. Each pass starts at a different rotated offset. At every word it runs a short march of seven accesses that mixes whole-word inversion with a single-bit toggle. When the march on a word is over, that word holds its original value again.

Every read is checked two ways. The stored check bits must agree with check bits regenerated from the returned data, and the data must match the value most recently written. The first disagreement sets a sticky fail flag and records the word address and the pass number. While the march on one word is in progress, the controller raises a lock so that the system arbiter keeps granting it. No other agent can then see or change the word while it is inverted or toggled.

Top module: `online_march_tester`

## Requirements
- R1: While reset is held and after it is released, busy, done, fail, mem_req and mem_lock are all low.
- R2: A start pulse seen while idle begins a run and clears the fail record. A start pulse seen while busy has no effect on the access sequence.
- R3: Pass p (0 to 3) visits address (i + p*DEPTH/4) mod DEPTH for i = 0 up to DEPTH-1 in ascending order. All seven accesses to one word finish before the next word is touched.
- R4: The accesses to each word, in order, are: read; write ~orig; read; write orig XOR mask; read; write orig; read. Here orig is the value returned by the first read, and mask is one-hot with bit (p mod DATA_W) set.
- R5: Every write carries valid check bits. In parity mode this is the XOR of all data bits. In Hamming mode, data bit k is placed at the k-th position (counting from 1) that is not a power of two, and check bit j is the XOR of the data bits whose position has bit j set.
- R6: mem_lock is high from the cycle after a word's first read is granted until that word's last read has been compared. It is low while the first read of a word is being requested.
- R7: On a fault-free memory, every word holds its original data and valid check bits when the run ends, including a word whose check bits were wrong before the run.
- R8: A check-bit mismatch or a data mismatch on any read sets fail. fail stays set until the next run starts. fail_addr and fail_pass keep the address and pass of the first mismatch.
- R9: done is a one-cycle pulse in the cycle after the last compare of pass 3, and busy is already low in that cycle.
- R10: A run issues exactly 4*7*DEPTH granted accesses.
- R11: A request that is not granted is held with the same address, direction and write data until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a test run (ignored while busy) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_pass | output | 2 | Pass number of the first mismatch |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Grant from the system arbiter |
| mem_lock | output | 1 | Word march in progress; arbiter must keep granting |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_wchk | output | CHK_W | Check bits for the write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read grant |
| mem_rchk | input | CHK_W | Stored check bits, valid with mem_rdata |

## Verification
The assertions assume that the arbiter grants every request made while mem_lock is high, and that the memory returns read data and check bits exactly one cycle after a granted read. The bench arbiter withholds grants pseudo-randomly, but only while mem_lock is low, and its memory model answers with that one-cycle latency. Injected faults (corrupted check bits, a stuck read bit, and dropped single-bit writes that begin in pass 2) change only the memory contents. The port protocol the assertions rely on is left untouched.

// File: rtl/omt_pkg.sv
package omt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_CHK  = 2'd2
   } omt_state_e;

   localparam int STEPS     = 7;
   localparam int PASS_CNT  = 4;

   // number of Hamming check bits for single-error correction
   function automatic int omt_ham_bits(input int dw);
      int r;
      r = 0;
      while ((1 << r) < dw + r + 1) r++;
      return r;
   endfunction

   function automatic int omt_chk_width(input int mode, input int dw);
      return (mode == 0) ? 1 : omt_ham_bits(dw);
   endfunction

   // codeword position (from 1) of data bit i: i-th non-power-of-two
   function automatic int omt_data_pos(input int i);
      int cnt;
      cnt = 0;
      for (int k = 3; k < 256; k++) begin
         if ((k & (k - 1)) != 0) begin
            if (cnt == i) return k;
            cnt++;
         end
      end
      return 0;
   endfunction

   // data bits covered by check bit j
   function automatic logic [63:0] omt_cover(input int j, input int dw);
      logic [63:0] m;
      m = '0;
      for (int i = 0; i < dw; i++)
         if (((omt_data_pos(i) >> j) & 1) != 0) m[i] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/omt_checkgen.sv
module omt_checkgen import omt_pkg::*; #(
   parameter int DATA_W     = 8,
   parameter int CHECK_MODE = 1,
   parameter int CHK_W      = omt_chk_width(CHECK_MODE, DATA_W)
)(
   input  logic [DATA_W-1:0] data,
   output logic [CHK_W-1:0]  chk
);

   if (CHK_W != omt_chk_width(CHECK_MODE, DATA_W)) begin : g_bad_w
      $error("omt_checkgen: CHK_W does not match CHECK_MODE");
   end

   if (CHECK_MODE == 0) begin : g_parity
      assign chk = ^data;
   end else begin : g_hamming
      for (genvar j = 0; j < CHK_W; j++) begin : g_bit
         localparam logic [63:0] COVER = omt_cover(j, DATA_W);
         assign chk[j] = ^(data & COVER[DATA_W-1:0]);
      end
   end

endmodule

// File: rtl/omt_walker.sv
module omt_walker #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              advance,
   output logic [ADDR_W-1:0] addr,
   output logic [1:0]        pass,
   output logic [DATA_W-1:0] mask,
   output logic              last_word
);

   localparam int DEPTH = 1 << ADDR_W;
   localparam logic [ADDR_W-1:0] IDX_MAX = ADDR_W'(DEPTH - 1);

   logic [ADDR_W-1:0] idx_q;
   logic [1:0]        pass_q;
   logic [ADDR_W-1:0] offset;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         pass_q <= '0;
      end else if (clear) begin
         idx_q  <= '0;
         pass_q <= '0;
      end else if (advance) begin
         if (idx_q == IDX_MAX) begin
            idx_q  <= '0;
            pass_q <= pass_q + 2'd1;
         end else begin
            idx_q  <= idx_q + 1'b1;
         end
      end
   end

   // quarter-depth rotation per pass, wraps modulo DEPTH
   assign offset    = ADDR_W'(pass_q) << (ADDR_W - 2);
   assign addr      = idx_q + offset;
   assign pass      = pass_q;
   assign last_word = (idx_q == IDX_MAX) && (pass_q == 2'd3);

   for (genvar b = 0; b < DATA_W; b++) begin : g_mask
      assign mask[b] = ((int'(pass_q) % DATA_W) == b);
   end

   // R3
   pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (advance && !clear && idx_q != IDX_MAX) |=> $stable(pass_q));

   // R4
   mask_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      advance |-> $onehot(mask));

endmodule

// File: rtl/omt_fault_rec.sv
module omt_fault_rec #(
   parameter int ADDR_W = 4
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              hit,
   input  logic [ADDR_W-1:0] hit_addr,
   input  logic [1:0]        hit_pass,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [1:0]        fail_pass
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail      <= 1'b0;
         fail_addr <= '0;
         fail_pass <= '0;
      end else if (clear) begin
         fail      <= 1'b0;
         fail_addr <= '0;
         fail_pass <= '0;
      end else if (hit && !fail) begin
         fail      <= 1'b1;
         fail_addr <= hit_addr;
         fail_pass <= hit_pass;
      end
   end

   // R8
   fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !clear) |=> (fail && $stable(fail_addr) && $stable(fail_pass)));

endmodule

// File: rtl/online_march_tester.sv
module online_march_tester import omt_pkg::*; #(
   parameter  int DATA_W     = 8,
   parameter  int ADDR_W     = 4,
   parameter  int CHECK_MODE = 1,
   localparam int CHK_W      = omt_chk_width(CHECK_MODE, DATA_W)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [1:0]        fail_pass,
   output logic              mem_req,
   input  logic              mem_gnt,
   output logic              mem_lock,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [CHK_W-1:0]  mem_wchk,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [CHK_W-1:0]  mem_rchk
);

   localparam logic [2:0] LAST_STEP = 3'(STEPS - 1);

   if (ADDR_W < 2) begin : g_bad_addr
      $error("online_march_tester: ADDR_W must be at least 2");
   end
   if (DATA_W < 2 || DATA_W > 64) begin : g_bad_data
      $error("online_march_tester: DATA_W must be in 2..64");
   end
   if (CHECK_MODE != 0 && CHECK_MODE != 1) begin : g_bad_mode
      $error("online_march_tester: CHECK_MODE must be 0 or 1");
   end

   omt_state_e        state_q;
   logic [2:0]        step_q;
   logic [DATA_W-1:0] orig_q;
   logic              done_q;

   logic [ADDR_W-1:0] w_addr;
   logic [1:0]        w_pass;
   logic [DATA_W-1:0] w_mask;
   logic              w_last;
   logic              launch;
   logic              advance;
   logic              word_end;
   logic [DATA_W-1:0] exp_d;
   logic [CHK_W-1:0]  rd_gen;
   logic              chk_bad;
   logic              data_bad;
   logic              hit;

   assign launch   = (state_q == ST_IDLE) && start;
   assign word_end = (state_q == ST_CHK) && (step_q == LAST_STEP);
   assign advance  = word_end && !w_last;

   omt_walker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_walker (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (launch),
      .advance   (advance),
      .addr      (w_addr),
      .pass      (w_pass),
      .mask      (w_mask),
      .last_word (w_last)
   );

   // expected word for the current step
   always_comb begin
      unique case (step_q)
         3'd1, 3'd2: exp_d = ~orig_q;
         3'd3, 3'd4: exp_d = orig_q ^ w_mask;
         default:    exp_d = orig_q;
      endcase
   end

   omt_checkgen #(.DATA_W(DATA_W), .CHECK_MODE(CHECK_MODE), .CHK_W(CHK_W)) u_wgen (
      .data (exp_d),
      .chk  (mem_wchk)
   );

   omt_checkgen #(.DATA_W(DATA_W), .CHECK_MODE(CHECK_MODE), .CHK_W(CHK_W)) u_rgen (
      .data (mem_rdata),
      .chk  (rd_gen)
   );

   assign chk_bad  = (mem_rchk != rd_gen);
   assign data_bad = (step_q != 3'd0) && (mem_rdata != exp_d);
   assign hit      = (state_q == ST_CHK) && (chk_bad || data_bad);

   omt_fault_rec #(.ADDR_W(ADDR_W)) u_fault (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (launch),
      .hit       (hit),
      .hit_addr  (w_addr),
      .hit_pass  (w_pass),
      .fail      (fail),
      .fail_addr (fail_addr),
      .fail_pass (fail_pass)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         step_q  <= '0;
         orig_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_REQ;
                  step_q  <= '0;
               end
            end
            ST_REQ: begin
               if (mem_gnt) begin
                  if (step_q[0]) step_q <= step_q + 3'd1;
                  else           state_q <= ST_CHK;
               end
            end
            ST_CHK: begin
               if (step_q == 3'd0) orig_q <= mem_rdata;
               if (step_q == LAST_STEP) begin
                  step_q <= '0;
                  if (w_last) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     state_q <= ST_REQ;
                  end
               end else begin
                  step_q  <= step_q + 3'd1;
                  state_q <= ST_REQ;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != ST_IDLE);
   assign done      = done_q;
   assign mem_req   = (state_q == ST_REQ);
   assign mem_we    = step_q[0];
   assign mem_addr  = w_addr;
   assign mem_wdata = exp_d;
   assign mem_lock  = (state_q == ST_CHK) || ((state_q == ST_REQ) && (step_q != 3'd0));

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

   // R6
   lock_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_lock && mem_req) |-> mem_gnt);

   // R6
   lock_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_lock |-> busy);

   // R9
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy ##1 !done));

   // R2
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !word_end) |=> busy);

endmodule

// File: tb/online_march_tester_tb_top.sv
module online_march_tester_tb_top;

   localparam int DW = 8;
   localparam int AW = 4;
   localparam int D  = 1 << AW;
   localparam int CW = 4;
   localparam int TOTAL_ACC = 4 * 7 * D;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic          busy, done, fail;
   logic [AW-1:0] fail_addr;
   logic [1:0]    fail_pass;
   logic          mem_req, mem_gnt, mem_lock, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic [CW-1:0] mem_wchk, mem_rchk;

   always #5 clk = ~clk;

   online_march_tester #(.DATA_W(DW), .ADDR_W(AW), .CHECK_MODE(1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
      .fail(fail), .fail_addr(fail_addr), .fail_pass(fail_pass),
      .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_lock(mem_lock), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wchk(mem_wchk),
      .mem_rdata(mem_rdata), .mem_rchk(mem_rchk)
   );

   int checks = 0;
   int errors = 0;

   logic [DW-1:0] mem_d  [D];
   logic [CW-1:0] mem_c  [D];
   logic [DW-1:0] init_d [D];

   bit stuck_run = 0, drop_run = 0, dchk = 1;
   int tp = 0, ti = 0, ts = 0, acc_cnt = 0, acc_pass = 0;
   logic [7:0] lfsr = 8'hA5;
   bit          prev_wait = 0;
   logic [AW-1:0] prev_addr;
   logic        prev_we;
   logic [DW-1:0] prev_wdata;

   // Hamming check bits written independently from the rule in R5
   function automatic logic [CW-1:0] ham(input logic [DW-1:0] d);
      logic [CW-1:0] c;
      int di;
      c  = '0;
      di = 0;
      for (int p = 1; di < DW; p++) begin
         if ((p & (p - 1)) != 0) begin
            for (int j = 0; j < CW; j++)
               if (p[j]) c[j] = c[j] ^ d[di];
            di++;
         end
      end
      return c;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // memory model: one-cycle read latency, optional faults
   always @(posedge clk) begin
      if (mem_req && mem_gnt) begin
         if (mem_we) begin
            if (!(drop_run && acc_pass >= 2 && mem_addr == AW'(6) &&
                  $countones(mem_wdata ^ mem_d[mem_addr]) == 1)) begin
               mem_d[mem_addr] <= mem_wdata;
               mem_c[mem_addr] <= mem_wchk;
            end
         end else begin
            mem_rdata <= mem_d[mem_addr] | ((stuck_run && mem_addr == AW'(5)) ? 8'h04 : 8'h00);
            mem_rchk  <= mem_c[mem_addr];
         end
      end
   end

   // arbiter plus access tracker, evaluated away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         mem_gnt = mem_lock ? 1'b1 : (lfsr[1:0] != 2'b00);
         if (prev_wait)  // R11
            chk(mem_req && mem_addr == prev_addr && mem_we == prev_we &&
                (!mem_we || mem_wdata == prev_wdata), "R11", "held request",
                {mem_req, mem_addr}, {1'b1, prev_addr});
         prev_wait  = mem_req && !mem_gnt;
         prev_addr  = mem_addr;
         prev_we    = mem_we;
         prev_wdata = mem_wdata;
         if (mem_req && mem_gnt) begin
            automatic logic [AW-1:0] ea   = AW'((ti + tp * (D / 4)) % D);
            automatic logic [DW-1:0] orig = init_d[ea];
            automatic logic [DW-1:0] msk  = DW'(1) << (tp % DW);
            automatic logic [DW-1:0] ed;
            case (ts)
               1:       ed = ~orig;
               3:       ed = orig ^ msk;
               default: ed = orig;
            endcase
            acc_pass = tp;
            // R3 address, R4 direction and data
            chk(mem_addr == ea && mem_we == ts[0] &&
                (!mem_we || !dchk || mem_wdata == ed), "R3/R4", "access",
                {mem_addr, mem_we, mem_wdata}, {ea, ts[0], ed});
            // R6
            chk(mem_lock == (ts != 0), "R6", "lock", mem_lock, ts != 0);
            // R5
            if (mem_we)
               chk(mem_wchk == ham(mem_wdata), "R5", "write check bits",
                   mem_wchk, ham(mem_wdata));
            acc_cnt++;
            if (ts == 6) begin
               ts = 0;
               if (ti == D - 1) begin ti = 0; tp++; end
               else ti++;
            end else ts++;
         end
      end else begin
         mem_gnt = 1'b0;
      end
   end

   task automatic do_run(input int kind, input logic [7:0] seed);
      int cyc;
      for (int a = 0; a < D; a++) begin
         init_d[a] = DW'(a * 29 + 3) ^ seed;
         mem_d[a]  = init_d[a];
         mem_c[a]  = ham(init_d[a]);
      end
      if (kind == 1) mem_c[10] = mem_c[10] ^ 4'h1;
      stuck_run = (kind == 2);
      drop_run  = (kind == 3);
      dchk      = (kind != 3);
      tp = 0; ti = 0; ts = 0; acc_cnt = 0; acc_pass = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      cyc = 0;
      while (!done && cyc < 20000) begin
         @(negedge clk);
         cyc++;
         start = (kind == 0 && (cyc == 50 || cyc == 51));   // R2 start while busy
      end
      start = 1'b0;
      chk(done, "R9", "done reached", done, 1);
      chk(!busy, "R9", "busy low at done", busy, 0);
      chk(acc_cnt == TOTAL_ACC, "R10", "access count (R2 restart ignored)", acc_cnt, TOTAL_ACC);
      @(negedge clk);
      chk(!done, "R9", "done one cycle", done, 0);
      case (kind)
         0, 4: begin
            chk(!fail, "R8", "clean run fail (R2 cleared)", fail, 0);
            for (int a = 0; a < D; a++)
               chk(mem_d[a] == init_d[a] && mem_c[a] == ham(init_d[a]), "R7",
                   "restored word", {mem_d[a], mem_c[a]}, {init_d[a], ham(init_d[a])});
         end
         1: begin
            chk(fail && fail_addr == AW'(10) && fail_pass == 2'd0, "R8", "check-bit fault",
                {fail, fail_addr, fail_pass}, {1'b1, 4'd10, 2'd0});
            for (int a = 0; a < D; a++)
               chk(mem_d[a] == init_d[a] && mem_c[a] == ham(init_d[a]), "R7",
                   "restored word with fresh check bits (R5)", {mem_d[a], mem_c[a]},
                   {init_d[a], ham(init_d[a])});
         end
         2: chk(fail && fail_addr == AW'(5) && fail_pass == 2'd0, "R8", "stuck bit, first fail kept",
                {fail, fail_addr, fail_pass}, {1'b1, 4'd5, 2'd0});
         default: chk(fail && fail_addr == AW'(6) && fail_pass == 2'd2, "R8", "late fault pass",
                {fail, fail_addr, fail_pass}, {1'b1, 4'd6, 2'd2});
      endcase
   endtask

   initial begin
      rst_n = 1'b0;
      start = 1'b0;
      mem_gnt = 1'b0;
      mem_rdata = '0;
      mem_rchk = '0;
      repeat (3) @(negedge clk);
      chk(!busy && !done && !fail && !mem_req && !mem_lock, "R1", "in reset",
          {busy, done, fail, mem_req, mem_lock}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !fail && !mem_req && !mem_lock, "R1", "after reset",
          {busy, done, fail, mem_req, mem_lock}, 0);
      do_run(0, 8'h00);
      do_run(1, 8'h5A);
      do_run(2, 8'h00);
      do_run(3, 8'hC3);
      do_run(4, 8'h3C);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog run did not end actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule